// File: doc/BRIEF.md
# SDRAM Command Protocol Checker with Per-Bank State Tracking

This block watches the command pins of a double-data-rate SDRAM channel and judges every command issued on them. On each rising clock edge it turns the chip-select, row strobe, column strobe, write enable, clock enable, bank address and A10 pins into a command code. It then checks that command against the state of the addressed bank, or of all banks, and against a set of minimum-interval counters. It sits beside a memory controller as a synthesizable protocol monitor and has no effect on the bus.

There are four banks by default, each with its own state machine. A bank is idle, opening (row activation in progress), open, waiting for auto-precharge, or closing (precharge in progress). Each bank also has counters for the activate-to-precharge, activate-to-activate and write-recovery limits. Two global counters cover the activate-to-activate spacing between different banks and the busy time after a refresh or mode-register write. A command that breaks a rule gets a one-cycle error pulse with a reason code. It leaves every bank state and every timer unchanged. All limits are parameters counted in clock cycles.

Top module: `sdram_cmd_checker`

## Requirements
- R1: The command is DESEL (code 0) when clock enable is low or chip select is high. Otherwise {ras_n,cas_n,we_n} decodes as 111 NOP (1), 110 burst stop (2), 011 activate (3), 101 read (4/5), 100 write (6/7), 010 precharge (8/9), 001 refresh (10) and 000 mode-register set (11). DESEL, NOP and burst stop are always legal. bank_o repeats the sampled bank address.
- R2: With A10 high, a read becomes read-with-auto-precharge (5), a write becomes write-with-auto-precharge (7) and a precharge becomes precharge-all (9). Precharge-all closes every open bank.
- R3: All outputs are registered and change one clock after the command edge. After reset every bank is idle (state 0), the command is 0, the legal flag is 1 and there is no error. Bank states are 3 bits per bank, bank b at bits [3b+2:3b], with idle 0, opening 1, open 2, auto-precharge pending 3 and closing 4.
- R4: A read or write to a bank that is opening gives error 4. A read or write to any other bank that is not open gives error 1. After an activate the bank reports opening and becomes open T_RCD cycles after the activate edge.
- R5: An activate to a bank that is not idle gives error 2.
- R6: An activate to an idle bank gives error 6 if fewer than T_RC cycles have passed since that bank's last accepted activate. It also gives error 6 if fewer than T_RRD cycles have passed since any accepted activate.
- R7: A precharge gives error 5 if it reaches an opening or open bank fewer than T_RAS cycles after that bank's activate, or fewer than T_WR cycles after a write to it. A precharge to an idle or closing bank is legal and changes nothing.
- R8: An accepted precharge puts an open bank in the closing state, and it returns to idle T_RP cycles after the precharge edge.
- R9: A read or write with auto-precharge puts the bank in the pending state. There, a read or write gives error 1 and a precharge gives error 2. The bank starts closing on the first edge at which its T_RAS and write-recovery limits are both met.
- R10: A refresh or mode-register set gives error 3 unless every bank is idle.
- R11: For T_MRD cycles after an accepted mode-register set, and T_RFC cycles after an accepted refresh, any command other than DESEL, NOP or burst stop gives error 7. This check comes before all others.
- R12: An illegal command drives legal_o low and err_valid_o high for one cycle, with the reason in err_code_o. It changes no bank state and restarts no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W (2) | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks selector |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BANK_W (2) | Sampled bank address |
| legal_o | output | 1 | Command is allowed |
| err_valid_o | output | 1 | One-cycle pulse for an illegal command |
| err_code_o | output | 3 | Reason for the error, 0 when legal |
| bank_state_o | output | 3*NUM_BANKS (12) | Packed per-bank state |

## Verification
The bench issues commands at the exact edge where a limit runs out and again one cycle before it, for the opening delay, activate-to-precharge, same-bank and cross-bank activate spacing, precharge time and refresh busy time. An off-by-one counter would therefore flip a legal flag at one of these edges. It issues an illegal activate inside the cross-bank window and then a legal one on the next edge. A design that reloaded a timer on a rejected command would reject that second activate. It drives auto-precharge through both the write and the read path. A design that closed the bank before write recovery, or accepted a precharge to a pending bank, would show the wrong state code or error. Precharge-all is also tested with one bank already closing, and clock enable is pulled low with activate pins present.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_ACT   = 4'd3,
    CMD_RD    = 4'd4,
    CMD_RDA   = 4'd5,
    CMD_WR    = 4'd6,
    CMD_WRA   = 4'd7,
    CMD_PRE   = 4'd8,
    CMD_PREA  = 4'd9,
    CMD_REF   = 4'd10,
    CMD_MRS   = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    BS_IDLE    = 3'd0,
    BS_OPENING = 3'd1,
    BS_OPEN    = 3'd2,
    BS_AUTOPRE = 3'd3,
    BS_CLOSING = 3'd4
  } bstate_e;

  typedef enum logic [2:0] {
    ER_NONE         = 3'd0,
    ER_COL_CLOSED   = 3'd1,
    ER_BANK_BUSY    = 3'd2,
    ER_NOT_ALL_IDLE = 3'd3,
    ER_TRCD         = 3'd4,
    ER_TRAS_TWR     = 3'd5,
    ER_TRC_TRRD     = 3'd6,
    ER_GLOBAL_BUSY  = 3'd7
  } err_e;

  // Pin-level decode; a low clock enable or a high select hides the pins.
  function automatic cmd_e decode_pins(input logic cke, input logic cs_n,
                                       input logic ras_n, input logic cas_n,
                                       input logic we_n, input logic a10);
    cmd_e c;
    c = CMD_DESEL;
    if (cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b110:  c = CMD_BST;
        3'b011:  c = CMD_ACT;
        3'b101:  c = a10 ? CMD_RDA  : CMD_RD;
        3'b100:  c = a10 ? CMD_WRA  : CMD_WR;
        3'b010:  c = a10 ? CMD_PREA : CMD_PRE;
        3'b001:  c = CMD_REF;
        default: c = CMD_MRS;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_column(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction

  function automatic logic is_quiet(input cmd_e c);
    return (c == CMD_DESEL) || (c == CMD_NOP) || (c == CMD_BST);
  endfunction

  function automatic logic is_open(input bstate_e s);
    return (s == BS_OPENING) || (s == BS_OPEN);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned width_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sdc_pin_decode.sv
module sdc_pin_decode
  import sdc_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd_o
);
  assign cmd_o = decode_pins(cke, cs_n, ras_n, cas_n, we_n, a10);
endmodule

// File: rtl/sdc_countdown.sv
module sdc_countdown #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int CW    = 4,
  parameter int T_RCD = 4,
  parameter int T_RP  = 3,
  parameter int T_RAS = 7,
  parameter int T_RC  = 12,
  parameter int T_WR  = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    act_i,
  input  logic    col_i,
  input  logic    col_wr_i,
  input  logic    col_ap_i,
  input  logic    pre_i,
  output bstate_e state_o,
  output logic    ras_ok_o,
  output logic    rc_ok_o,
  output logic    wr_ok_o
);
  localparam bstate_e AFTER_ACT = (T_RCD > 1) ? BS_OPENING : BS_OPEN;
  localparam bstate_e AFTER_PRE = (T_RP > 1)  ? BS_CLOSING : BS_IDLE;

  bstate_e       st_q, st_d;
  logic [CW-1:0] ph_q, ph_d;
  logic          start_pre;
  logic          ph_last;

  assign ph_last = (ph_q <= CW'(1));

  always_comb begin
    st_d      = st_q;
    ph_d      = (ph_q != '0) ? ph_q - CW'(1) : ph_q;
    start_pre = 1'b0;
    case (st_q)
      BS_IDLE: if (act_i) begin
        st_d = AFTER_ACT;
        ph_d = CW'(T_RCD - 1);
      end
      BS_OPENING: begin
        if (pre_i)        start_pre = 1'b1;
        else if (ph_last) st_d = BS_OPEN;
      end
      BS_OPEN: begin
        if (pre_i)                   start_pre = 1'b1;
        else if (col_i && col_ap_i)  st_d = BS_AUTOPRE;
      end
      BS_AUTOPRE: if (ras_ok_o && wr_ok_o) start_pre = 1'b1;
      BS_CLOSING: if (ph_last) st_d = BS_IDLE;
      default:    st_d = BS_IDLE;
    endcase
    if (start_pre) begin
      st_d = AFTER_PRE;
      ph_d = CW'(T_RP - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BS_IDLE;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign state_o = st_q;

  sdc_countdown #(.CW(CW)) u_ras (
    .clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(CW'(T_RAS - 1)), .zero_o(ras_ok_o));
  sdc_countdown #(.CW(CW)) u_rc (
    .clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(CW'(T_RC - 1)), .zero_o(rc_ok_o));
  sdc_countdown #(.CW(CW)) u_wr (
    .clk(clk), .rst_n(rst_n), .load_i(col_i && col_wr_i), .val_i(CW'(T_WR - 1)),
    .zero_o(wr_ok_o));

  // R5: an accepted activate only ever reaches an idle bank
  a_r5_act_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (st_q == BS_IDLE));

  // R4: accepted column commands only reach an open bank
  a_r4_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> (st_q == BS_OPEN));

  // R7: an accepted precharge to an open bank respects tRAS and write recovery
  a_r7_pre_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && is_open(st_q)) |-> (ras_ok_o && wr_ok_o));

  // R8: a closing bank can only stay closing or become idle
  a_r8_closing_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_CLOSING) |=> (st_q == BS_CLOSING || st_q == BS_IDLE));

  // R9: auto-precharge waits while either limit is still running
  a_r9_autopre_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_AUTOPRE && !(ras_ok_o && wr_ok_o)) |=> (st_q == BS_AUTOPRE));
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 4,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 7,
  parameter int T_RC      = 12,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_RFC     = 15,
  localparam int BANK_W   = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BANK_W-1:0]      ba,
  input  logic                   a10,
  output logic [3:0]             cmd_o,
  output logic [BANK_W-1:0]      bank_o,
  output logic                   legal_o,
  output logic                   err_valid_o,
  output logic [2:0]             err_code_o,
  output logic [3*NUM_BANKS-1:0] bank_state_o
);
  localparam int unsigned TMAX = max2(max2(max2(T_RCD, T_RP), max2(T_RAS, T_RC)),
                                      max2(max2(T_RRD, T_MRD), max2(T_WR, T_RFC)));
  localparam int CW = width_for(TMAX);

  cmd_e    cmd_dec;
  bstate_e st [NUM_BANKS];
  logic [NUM_BANKS-1:0] ras_ok, rc_ok, wr_ok;
  logic    rrd_zero, busy_zero;
  logic    all_idle, any_ap, any_pre_viol;
  err_e    err_d;
  logic    legal_d;
  bstate_e tgt;

  sdc_pin_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
    .cmd_o(cmd_dec));

  assign tgt = st[ba];

  always_comb begin
    all_idle     = 1'b1;
    any_ap       = 1'b0;
    any_pre_viol = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (st[b] != BS_IDLE)    all_idle = 1'b0;
      if (st[b] == BS_AUTOPRE) any_ap   = 1'b1;
      if (is_open(st[b]) && !(ras_ok[b] && wr_ok[b])) any_pre_viol = 1'b1;
    end
  end

  // Legality: global busy first, then bank state, then timing.
  always_comb begin
    err_d = ER_NONE;
    if (!is_quiet(cmd_dec) && !busy_zero) begin
      err_d = ER_GLOBAL_BUSY;
    end else begin
      case (cmd_dec)
        CMD_ACT: begin
          if (tgt != BS_IDLE)                err_d = ER_BANK_BUSY;
          else if (!rc_ok[ba] || !rrd_zero)  err_d = ER_TRC_TRRD;
        end
        CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
          if (tgt == BS_OPENING)             err_d = ER_TRCD;
          else if (tgt != BS_OPEN)           err_d = ER_COL_CLOSED;
        end
        CMD_PRE: begin
          if (tgt == BS_AUTOPRE)             err_d = ER_BANK_BUSY;
          else if (is_open(tgt) && !(ras_ok[ba] && wr_ok[ba])) err_d = ER_TRAS_TWR;
        end
        CMD_PREA: begin
          if (any_ap)                        err_d = ER_BANK_BUSY;
          else if (any_pre_viol)             err_d = ER_TRAS_TWR;
        end
        CMD_REF, CMD_MRS: begin
          if (!all_idle)                     err_d = ER_NOT_ALL_IDLE;
        end
        default: err_d = ER_NONE;
      endcase
    end
  end

  assign legal_d = (err_d == ER_NONE);

  logic act_ok, col_ok, col_wr, col_ap;
  assign act_ok = legal_d && (cmd_dec == CMD_ACT);
  assign col_ok = legal_d && is_column(cmd_dec);
  assign col_wr = (cmd_dec == CMD_WR)  || (cmd_dec == CMD_WRA);
  assign col_ap = (cmd_dec == CMD_RDA) || (cmd_dec == CMD_WRA);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit, act_g, col_g, pre_g;
    assign hit   = (ba == BANK_W'(g));
    assign act_g = act_ok && hit;
    assign col_g = col_ok && hit;
    assign pre_g = legal_d && is_open(st[g]) &&
                   (((cmd_dec == CMD_PRE) && hit) || (cmd_dec == CMD_PREA));

    sdc_bank #(.CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
               .T_RC(T_RC), .T_WR(T_WR)) u_bank (
      .clk(clk), .rst_n(rst_n), .act_i(act_g), .col_i(col_g), .col_wr_i(col_wr),
      .col_ap_i(col_ap), .pre_i(pre_g), .state_o(st[g]), .ras_ok_o(ras_ok[g]),
      .rc_ok_o(rc_ok[g]), .wr_ok_o(wr_ok[g]));

    assign bank_state_o[3*g +: 3] = st[g];
  end

  logic          busy_load;
  logic [CW-1:0] busy_val;
  assign busy_load = legal_d && ((cmd_dec == CMD_REF) || (cmd_dec == CMD_MRS));
  assign busy_val  = (cmd_dec == CMD_REF) ? CW'(T_RFC - 1) : CW'(T_MRD - 1);

  sdc_countdown #(.CW(CW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load_i(act_ok), .val_i(CW'(T_RRD - 1)), .zero_o(rrd_zero));
  sdc_countdown #(.CW(CW)) u_busy (
    .clk(clk), .rst_n(rst_n), .load_i(busy_load), .val_i(busy_val), .zero_o(busy_zero));

  cmd_e              cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic              legal_q, errv_q;
  err_e              errc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_DESEL;
      bank_q  <= '0;
      legal_q <= 1'b1;
      errv_q  <= 1'b0;
      errc_q  <= ER_NONE;
    end else begin
      cmd_q   <= cmd_dec;
      bank_q  <= ba;
      legal_q <= legal_d;
      errv_q  <= !legal_d;
      errc_q  <= err_d;
    end
  end

  assign cmd_o       = cmd_q;
  assign bank_o      = bank_q;
  assign legal_o     = legal_q;
  assign err_valid_o = errv_q;
  assign err_code_o  = errc_q;

  // R11: a non-quiet command while the global timer runs is flagged next cycle
  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_zero && !is_quiet(cmd_dec)) |=> (err_valid_o && err_code_o == 3'd7));

  // R10: refresh or mode set with a non-idle bank is always reported
  a_r10_needs_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_dec == CMD_REF || cmd_dec == CMD_MRS) && !all_idle) |=> err_valid_o);

  // R6: two accepted activates never fall inside the cross-bank window
  a_r6_rrd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ok && T_RRD > 1) |=> !act_ok);
endmodule

// File: tb/tb_sdram_cmd_checker.sv
`timescale 1ns/1ps
module tb_sdram_cmd_checker;
  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic legal_o, err_valid_o;
  logic [2:0] err_code_o;
  logic [11:0] bank_state_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_checker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_o(bank_o), .legal_o(legal_o),
    .err_valid_o(err_valid_o), .err_code_o(err_code_o), .bank_state_o(bank_state_o));

  // pin patterns {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_BST = 4'b0110,
                         P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;

  // {pins, ba, a10, cmd, legal, err, states{b3,b2,b1,b0}, requirement}
  localparam int NV = 23;
  localparam logic [30:0] VEC [NV] = '{
    {P_NOP,2'd0,1'b0,4'd1, 1'b1,3'd0,{3'd0,3'd0,3'd0,3'd0},4'd1},  // R1 NOP
    {P_MRS,2'd0,1'b0,4'd11,1'b1,3'd0,{3'd0,3'd0,3'd0,3'd0},4'd10}, // R10 mode set, all idle
    {P_ACT,2'd0,1'b0,4'd3, 1'b0,3'd7,{3'd0,3'd0,3'd0,3'd0},4'd11}, // R11 inside tMRD
    {P_ACT,2'd0,1'b0,4'd3, 1'b1,3'd0,{3'd0,3'd0,3'd0,3'd1},4'd1},  // R1 activate b0
    {P_ACT,2'd1,1'b0,4'd3, 1'b0,3'd6,{3'd0,3'd0,3'd0,3'd1},4'd6},  // R6 tRRD
    {P_ACT,2'd1,1'b0,4'd3, 1'b1,3'd0,{3'd0,3'd0,3'd1,3'd1},4'd12}, // R12 timer not reloaded
    {P_RD, 2'd0,1'b0,4'd4, 1'b0,3'd4,{3'd0,3'd0,3'd1,3'd2},4'd4},  // R4 tRCD edge-1
    {P_RD, 2'd0,1'b0,4'd4, 1'b1,3'd0,{3'd0,3'd0,3'd1,3'd2},4'd4},  // R4 read open bank
    {P_PRE,2'd0,1'b0,4'd8, 1'b0,3'd5,{3'd0,3'd0,3'd2,3'd2},4'd7},  // R7 tRAS
    {P_WR, 2'd1,1'b1,4'd7, 1'b1,3'd0,{3'd0,3'd0,3'd3,3'd2},4'd9},  // R9 write with AP
    {P_REF,2'd0,1'b0,4'd10,1'b0,3'd3,{3'd0,3'd0,3'd3,3'd2},4'd10}, // R10 banks open
    {P_RD, 2'd1,1'b0,4'd4, 1'b0,3'd1,{3'd0,3'd0,3'd3,3'd2},4'd9},  // R9 column to AP bank
    {P_ACT,2'd0,1'b0,4'd3, 1'b0,3'd2,{3'd0,3'd0,3'd4,3'd2},4'd5},  // R5 act to open bank
    {P_PRE,2'd1,1'b0,4'd8, 1'b1,3'd0,{3'd0,3'd0,3'd4,3'd2},4'd7},  // R7 pre to closing
    {P_PRE,2'd0,1'b1,4'd9, 1'b1,3'd0,{3'd0,3'd0,3'd0,3'd4},4'd2},  // R2 precharge all
    {P_ACT,2'd1,1'b0,4'd3, 1'b0,3'd6,{3'd0,3'd0,3'd0,3'd4},4'd6},  // R6 tRC
    {P_NOP,2'd0,1'b0,4'd1, 1'b1,3'd0,{3'd0,3'd0,3'd0,3'd0},4'd8},  // R8 closing to idle
    {P_ACT,2'd1,1'b0,4'd3, 1'b1,3'd0,{3'd0,3'd0,3'd1,3'd0},4'd6},  // R6 tRC boundary
    {P_ACT,2'd2,1'b0,4'd3, 1'b0,3'd6,{3'd0,3'd0,3'd1,3'd0},4'd6},  // R6 tRRD again
    {P_WR, 2'd2,1'b0,4'd6, 1'b0,3'd1,{3'd0,3'd0,3'd1,3'd0},4'd4},  // R4 write to idle
    {P_DES,2'd3,1'b0,4'd0, 1'b1,3'd0,{3'd0,3'd0,3'd2,3'd0},4'd1},  // R1 deselect
    {P_BST,2'd0,1'b0,4'd2, 1'b1,3'd0,{3'd0,3'd0,3'd2,3'd0},4'd1},  // R1 burst stop
    {P_PRE,2'd1,1'b1,4'd9, 1'b0,3'd5,{3'd0,3'd0,3'd2,3'd0},4'd7}   // R7 prea tRAS
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] p, input logic [1:0] b, input logic a);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba  = b;
    a10 = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int st_of(input int b);
    return int'(bank_state_o[3*b +: 3]);
  endfunction

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_DES; ba = '0; a10 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3 reset state
    chk("R3", "reset cmd", int'(cmd_o), 0);
    chk("R3", "reset legal", int'(legal_o), 1);
    chk("R3", "reset err_valid", int'(err_valid_o), 0);
    chk("R3", "reset states", int'(bank_state_o), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d vec%0d", v[3:0], i);
      issue(v[30:27], v[26:25], v[24]);
      chk(rq, "cmd", int'(cmd_o), int'(v[23:20]));
      chk(rq, "bank", int'(bank_o), int'(v[26:25]));
      chk(rq, "legal", int'(legal_o), int'(v[19]));
      chk(rq, "err_code", int'(err_code_o), int'(v[18:16]));
      chk(rq, "err_valid", int'(err_valid_o), int'(v[18:16] != 3'd0));
      chk(rq, "states", int'(bank_state_o), int'(v[15:4]));
    end

    // R1: clock enable low hides an activate
    cke = 1'b0;
    issue(P_ACT, 2'd2, 1'b0);
    chk("R1", "cke low cmd", int'(cmd_o), 0);
    chk("R1", "cke low legal", int'(legal_o), 1);
    chk("R1", "cke low bank2", st_of(2), 0);
    cke = 1'b1;
    repeat (4) issue(P_NOP, 2'd0, 1'b0);
    // R8: precharge bank1, idle after T_RP
    issue(P_PRE, 2'd1, 1'b0);
    chk("R8", "pre legal", int'(legal_o), 1);
    chk("R8", "bank1 closing", st_of(1), 4);
    issue(P_NOP, 2'd0, 1'b0);
    chk("R8", "bank1 still closing", st_of(1), 4);
    issue(P_NOP, 2'd0, 1'b0);
    chk("R8", "bank1 idle", st_of(1), 0);
    // R10 refresh with all idle, then R11 busy window
    issue(P_REF, 2'd0, 1'b0);
    chk("R10", "ref legal", int'(legal_o), 1);
    repeat (13) issue(P_NOP, 2'd0, 1'b0);
    issue(P_ACT, 2'd0, 1'b0);
    chk("R11", "act at tRFC-1", int'(err_code_o), 7);
    chk("R12", "bank0 untouched", st_of(0), 0);
    issue(P_ACT, 2'd0, 1'b0);
    chk("R11", "act at tRFC", int'(legal_o), 1);
    chk("R4", "bank0 opening", st_of(0), 1);
    repeat (3) issue(P_NOP, 2'd0, 1'b0);
    chk("R4", "bank0 open after tRCD", st_of(0), 2);
    // R9 read with auto-precharge
    issue(P_RD, 2'd0, 1'b1);
    chk("R2", "read AP cmd", int'(cmd_o), 5);
    chk("R9", "bank0 pending", st_of(0), 3);
    issue(P_PRE, 2'd0, 1'b0);
    chk("R9", "pre to pending bank", int'(err_code_o), 2);
    chk("R9", "still pending", st_of(0), 3);
    issue(P_NOP, 2'd0, 1'b0);
    chk("R9", "pending until tRAS", st_of(0), 3);
    issue(P_NOP, 2'd0, 1'b0);
    chk("R9", "closing after tRAS", st_of(0), 4);
    issue(P_NOP, 2'd0, 1'b0);
    issue(P_NOP, 2'd0, 1'b0);
    chk("R9", "idle after tRP", st_of(0), 0);
    // R3 reset in mid-run
    issue(P_ACT, 2'd3, 1'b0);
    chk("R3", "bank3 opening", st_of(3), 1);
    rst_n = 1'b0;
    #1;
    chk("R3", "reset states", int'(bank_state_o), 0);
    chk("R3", "reset cmd", int'(cmd_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    summary();
    $finish;
  end
endmodule